// File: doc/BRIEF.md
# Alternating Parity Puncturer

This block sits in the bit stream right after a systematic encoder whose parity section has a dual-diagonal check structure. Each frame is INFO_LEN information bits followed by PAR_LEN parity bits, one bit per valid cycle. Every information bit is passed through. Within the parity section, a chosen number of bits is removed so that the transmitted frame is shorter and the code rate is higher.

Erasures use an alternating pattern that starts at the beginning of the parity section. Parity bit 0 is kept, parity bit 1 is dropped, parity bit 2 is kept, and the pattern repeats until the requested number of erasures has been made. Every parity bit after that point is kept. Because the pattern alternates, no two neighbouring parity bits are ever both removed, so each parity check loses at most one of its bits. The erase count can be at most half the parity length. With a rate-1/2 mother code, this lets the rate range from 1/2 up to 2/3.

The control is a two-state machine. ST_INFO covers the information section and is also the frame-start state. ST_PARITY covers the parity section. The machine has three transitions:
- T_ENTER_PARITY moves from ST_INFO to ST_PARITY on the last information bit.
- T_FRAME_DONE moves from ST_PARITY to ST_INFO on the final parity bit.
- T_RESYNC returns to ST_INFO from either state whenever a bit arrives flagged as last.

The output is registered, so a kept bit appears one cycle after it is accepted.

Top module: `apu_puncture`

## Requirements
- R1: Every information bit (frame positions 0 to INFO_LEN-1) is forwarded unchanged and in order. The kept bit appears with out_valid high exactly one cycle after it was accepted.
- R2: Parity index j counts from 0 at frame position INFO_LEN. With E the effective erase count, parity bit j is dropped if and only if j is odd and (j-1)/2 < E. All other parity bits are forwarded unchanged.
- R3: Two consecutive accepted bits are never both dropped.
- R4: The erase request is sampled only on the first valid bit of a frame. Changes to erase_req during the rest of the frame have no effect on that frame.
- R5: A request larger than floor(PAR_LEN/2) is clamped to floor(PAR_LEN/2).
- R6: out_last is high on the final transmitted bit of a frame and on no other bit. When PAR_LEN is even and E equals PAR_LEN/2, the last parity bit is dropped, and out_last is then carried by parity bit PAR_LEN-2.
- R7: A full frame produces exactly INFO_LEN+PAR_LEN-E output bits.
- R8: After reset, out_valid and out_last are low. A cycle with in_valid low produces no output and does not advance the frame position.
- R9: A valid bit with in_last high ends the frame. The next valid bit is position 0 of a new frame, even if the previous frame was short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | Encoded bit |
| in_last | input | 1 | Final bit of the input frame |
| erase_req | input | $clog2(PAR_LEN+1) | Requested number of parity erasures, sampled at frame start |
| out_valid | output | 1 | Output bit present this cycle |
| out_bit | output | 1 | Transmitted bit |
| out_last | output | 1 | Final transmitted bit of the frame |

## Verification
The bound checker verifies, on every cycle, the properties that need only local history:
- each output comes from an input accepted one cycle earlier and carries that input's value;
- no drop immediately follows another drop;
- the number of drops in a frame never exceeds half the parity length;
- out_last never appears without out_valid.

Other behaviour can only be shown by the bench scenarios, because it depends on the frame position and the requested count: the exact positions that are dropped, the clamping of oversized requests, a request that changes in the middle of a frame, the shift of out_last when the final parity bit is erased, the output length, and recovery after a short frame.

// File: rtl/apu_pkg.sv
package apu_pkg;

    typedef enum logic [0:0] {
        ST_INFO   = 1'b0,
        ST_PARITY = 1'b1
    } apu_state_e;

endpackage

// File: rtl/apu_drop_rule.sv
module apu_drop_rule #(
    parameter int PAR_LEN = 480,
    parameter int CNT_W   = 9,
    parameter int POS_W   = 10
) (
    input  logic             in_parity,
    input  logic [POS_W-1:0] par_idx,
    input  logic [CNT_W-1:0] erase_cnt,
    output logic             keep,
    output logic             final_keep
);

    localparam int HALF = PAR_LEN / 2;

    logic [POS_W-1:0] pair_idx;
    logic [POS_W-1:0] last_idx;
    logic             dropped;

    // odd parity positions are candidates; the first erase_cnt of them go
    assign pair_idx = par_idx >> 1;
    assign dropped  = in_parity && par_idx[0] && (pair_idx < POS_W'(erase_cnt));
    assign keep     = !dropped;

    generate
        if (PAR_LEN % 2 == 0) begin : g_even
            // the final parity bit is odd-indexed and erasable at full budget
            assign last_idx = (erase_cnt == CNT_W'(HALF)) ? POS_W'(PAR_LEN - 2)
                                                          : POS_W'(PAR_LEN - 1);
        end else begin : g_odd
            assign last_idx = POS_W'(PAR_LEN - 1);
        end
    endgenerate

    assign final_keep = in_parity && (par_idx == last_idx);

endmodule

// File: rtl/apu_frame_fsm.sv
module apu_frame_fsm
    import apu_pkg::*;
#(
    parameter int INFO_LEN = 480,
    parameter int PAR_LEN  = 480,
    parameter int CNT_W    = 9,
    parameter int POS_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [CNT_W-1:0] erase_req,
    output apu_state_e       state_o,
    output logic [POS_W-1:0] par_idx_o,
    output logic [CNT_W-1:0] erase_o
);

    localparam int               FRAME_LEN = INFO_LEN + PAR_LEN;
    localparam logic [POS_W-1:0] LAST_INFO = POS_W'(INFO_LEN - 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] HALF_C    = CNT_W'(PAR_LEN / 2);

    apu_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] erase_q, erase_d;
    logic [CNT_W-1:0] erase_clamped;

    assign erase_clamped = (erase_req > HALF_C) ? HALF_C : erase_req;

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        erase_d = erase_q;
        if (in_valid) begin
            unique case (state_q)
                ST_INFO: begin
                    if (pos_q == '0) begin
                        erase_d = erase_clamped;
                    end
                    if (in_last) begin
                        pos_d = '0;                      // T_RESYNC
                    end else if (pos_q == LAST_INFO) begin
                        state_d = ST_PARITY;             // T_ENTER_PARITY
                        pos_d   = pos_q + POS_W'(1);
                    end else begin
                        pos_d = pos_q + POS_W'(1);
                    end
                end
                ST_PARITY: begin
                    if (in_last || pos_q == LAST_POS) begin
                        state_d = ST_INFO;               // T_FRAME_DONE / T_RESYNC
                        pos_d   = '0;
                    end else begin
                        pos_d = pos_q + POS_W'(1);
                    end
                end
                default: begin
                    state_d = ST_INFO;
                    pos_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INFO;
            pos_q   <= '0;
            erase_q <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            erase_q <= erase_d;
        end
    end

    assign state_o   = state_q;
    assign par_idx_o = pos_q - POS_W'(INFO_LEN);
    assign erase_o   = erase_q;

endmodule

// File: rtl/apu_puncture.sv
module apu_puncture
    import apu_pkg::*;
#(
    parameter  int INFO_LEN = 480,
    parameter  int PAR_LEN  = 480,
    localparam int CNT_W    = $clog2(PAR_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             in_last,
    input  logic [CNT_W-1:0] erase_req,
    output logic             out_valid,
    output logic             out_bit,
    output logic             out_last
);

    localparam int POS_W = $clog2(INFO_LEN + PAR_LEN);

    apu_state_e       state;
    logic [POS_W-1:0] par_idx;
    logic [CNT_W-1:0] erase_cnt;
    logic             keep;
    logic             final_keep;

    apu_frame_fsm #(
        .INFO_LEN (INFO_LEN),
        .PAR_LEN  (PAR_LEN),
        .CNT_W    (CNT_W),
        .POS_W    (POS_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .erase_req (erase_req),
        .state_o   (state),
        .par_idx_o (par_idx),
        .erase_o   (erase_cnt)
    );

    apu_drop_rule #(
        .PAR_LEN (PAR_LEN),
        .CNT_W   (CNT_W),
        .POS_W   (POS_W)
    ) u_rule (
        .in_parity  (state == ST_PARITY),
        .par_idx    (par_idx),
        .erase_cnt  (erase_cnt),
        .keep       (keep),
        .final_keep (final_keep)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= in_valid && keep;
            out_bit   <= in_bit;
            out_last  <= in_valid && keep && final_keep;
        end
    end

endmodule

// File: rtl/apu_puncture_chk.sv
module apu_puncture_chk #(
    parameter int INFO_LEN = 480,
    parameter int PAR_LEN  = 480
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_bit,
    input logic in_last,
    input logic out_valid,
    input logic out_bit,
    input logic out_last
);

    localparam int HALF = PAR_LEN / 2;

    logic        pv, pb, pl;
    logic        prev_drop;
    int unsigned drop_cnt;
    logic        drop_ev;

    assign drop_ev = pv && !out_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv        <= 1'b0;
            pb        <= 1'b0;
            pl        <= 1'b0;
            prev_drop <= 1'b0;
            drop_cnt  <= 0;
        end else begin
            pv <= in_valid;
            pb <= in_bit;
            pl <= in_valid && in_last;
            if (pv) prev_drop <= !out_valid;
            drop_cnt <= pl ? 0 : drop_cnt + (drop_ev ? 1 : 0);
        end
    end

    AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pv);                               // R1
    AST_BIT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == pb));                  // R1
    AST_NO_ADJ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        drop_ev |-> !prev_drop);                         // R3
    AST_DROP_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        drop_ev |-> (drop_cnt < HALF));                  // R5
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);                         // R6

endmodule

bind apu_puncture apu_puncture_chk #(
    .INFO_LEN (INFO_LEN),
    .PAR_LEN  (PAR_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_last  (out_last)
);

// File: tb/apu_puncture_test.sv
module apu_puncture_test;

    localparam int K      = 12;
    localparam int M      = 10;
    localparam int N      = K + M;
    localparam int CW     = $clog2(M + 1);
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_bit, in_last;
    logic [CW-1:0] erase_req;
    logic          out_valid, out_bit, out_last;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    apu_puncture #(.INFO_LEN(K), .PAR_LEN(M)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_last   (in_last),
        .erase_req (erase_req),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_of(input int req);
        return (req > M / 2) ? M / 2 : req;
    endfunction

    function automatic bit exp_keep(input int p, input int eff);
        int j;
        if (p < K) return 1'b1;
        j = p - K;
        return !((j % 2 == 1) && (j / 2 < eff));
    endfunction

    function automatic int exp_final(input int eff);
        return ((M % 2 == 0) && (eff == M / 2)) ? N - 2 : N - 1;
    endfunction

    task automatic idle_cycle();
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 idle out_valid", int'(out_valid), 0);
    endtask

    task automatic run_frame(input int req, input int len, input bit wiggle,
                             input int gap_pct, input string tag);
        int eff, fin, outs, exp_len;
        bit prev_drop;
        eff       = eff_of(req);
        fin       = exp_final(eff);
        outs      = 0;
        exp_len   = 0;
        prev_drop = 1'b0;
        for (int p = 0; p < len; p++) begin
            bit b, ek, el;
            while (int'($urandom % 100) < gap_pct) idle_cycle();
            b         = 1'($urandom);
            in_valid  = 1'b1;
            in_bit    = b;
            in_last   = (p == len - 1);
            erase_req = (p == 0 || !wiggle) ? CW'(req) : CW'($urandom);
            @(posedge clk);
            @(negedge clk);
            ek = exp_keep(p, eff);
            el = ek && (p == fin);
            if (ek) exp_len++;
            if (p < K) chk(out_valid == ek, "R1 info kept", int'(out_valid), int'(ek));
            else       chk(out_valid == ek, "R2 parity keep/drop", int'(out_valid), int'(ek));
            if (ek && out_valid) chk(out_bit == b, "R1 bit value", int'(out_bit), int'(b));
            chk(out_last == el, "R6 out_last", int'(out_last), int'(el));
            if (!out_valid) begin
                chk(!prev_drop, "R3 adjacent drops", 1, 0);
                prev_drop = 1'b1;
            end else begin
                prev_drop = 1'b0;
                outs++;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (len == N) chk(exp_len == N - eff, "R7 model length", exp_len, N - eff);
        chk(outs == exp_len, {tag, " frame length"}, outs, exp_len);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_bit    = 1'b0;
        in_last   = 1'b0;
        erase_req = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
        chk(out_last == 1'b0, "R8 reset out_last", int'(out_last), 0);
        rst_n = 1'b1;
        idle_cycle();

        run_frame(0, N, 1'b0, 0, "R7");           // nothing erased
        run_frame(M / 2, N, 1'b0, 0, "R6");       // full budget, last parity dropped
        run_frame(M, N, 1'b0, 0, "R5");           // oversized request clamped
        run_frame(15, N, 1'b0, 0, "R5");
        run_frame(1, N, 1'b0, 0, "R2");
        run_frame(M / 2 - 1, N, 1'b0, 0, "R2");
        run_frame(2, N, 1'b1, 0, "R4");           // request changes mid-frame
        run_frame(M / 2, N, 1'b1, 0, "R4");
        run_frame(3, 5, 1'b0, 0, "R9");           // short frame ends on in_last
        run_frame(4, N, 1'b0, 20, "R9");          // next frame starts clean
        for (int f = 0; f < 40; f++) begin
            run_frame(int'($urandom % (M + 1)), N, 1'($urandom), 30, "R7");
        end
        idle_cycle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule